// File: doc/BRIEF.md
# Pipeline Register File with Same-Cycle Write Bypass

This block holds the general-purpose registers of a five-stage pipelined processor. The decode stage reads two source operands through two independent combinational read ports. The write-back stage updates one register per cycle through a single write port. Every state element updates on the rising clock edge only.

A write presented in a cycle reaches the storage array only at the closing clock edge. The decode stage may read that same register in that same cycle. For this case, each read port compares its address with the pending write address. On a match it forwards the incoming write data in place of the stored word. The decode stage therefore always sees the newest value without using the falling edge.

Register zero is hard-wired to zero. Writes to it are dropped, and it never takes part in the bypass. A synchronous active-low reset clears every register.

Top module: `regfile_bypass`

## Requirements
- R1: Each read port returns the stored word of the register at its address combinationally, in the same cycle the address is applied, with no clock edge in between.
- R2: When `wr_en` is 1 and `wr_addr` is nonzero at a rising edge, `wr_data` is stored and both read ports return it from the next cycle on.
- R3: A cycle with `wr_en` = 0 leaves every stored register unchanged.
- R4: On read port A, if `wr_en` is 1, `wr_addr` equals `rd_addr_a` and the address is nonzero, `rd_data_a` equals `wr_data` in that same cycle.
- R5: Read port B bypasses under the same rule as port A, on its own. When both ports read the register being written, both return `wr_data`.
- R6: With `wr_en` = 0, a read whose address equals `wr_addr` returns the stored word and not `wr_data`.
- R7: Address 0 always reads as zero on both ports. A write to address 0 is ignored, both in the same cycle and afterwards.
- R8: When `rst_n` is 0 at a rising edge, every register is cleared to zero.
- R9: A write to one register changes neither the stored value nor the same-cycle read value of any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | ADDR_W (5) | Register written at the end of the cycle |
| wr_data | input | DATA_W (32) | Word to write |
| rd_addr_a | input | ADDR_W (5) | Source register address, port A |
| rd_data_a | output | DATA_W (32) | Operand A, combinational |
| rd_addr_b | input | ADDR_W (5) | Source register address, port B |
| rd_data_b | output | DATA_W (32) | Operand B, combinational |

## Verification
Several read and write patterns are driven against a reference model in the bench. The first is a write with both ports reading the same register, which tells same-cycle forwarding apart from the delayed array update. The second is a matching address with the enable low, which separates a bypass qualified by the enable from one that compares addresses only. Writes to register zero, and writes to one register while other registers are being read, expose a missing zero guard and a comparator that is too wide. A full sweep and a reset in mid-run show whether every entry is stored and whether every entry is cleared.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_NUM_REGS = 32;
    localparam int RF_DATA_W   = 32;
    localparam int RF_NUM_RD   = 2;
endpackage

// File: rtl/rf_wr_gate.sv
module rf_wr_gate #(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              wr_valid_o
);
    // A write only counts when it targets a real (nonzero) register.
    always_comb begin
        wr_valid_o = wr_en_i && (wr_addr_i != '0);
    end
endmodule

// File: rtl/rf_array.sv
module rf_array #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_valid_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_valid_i && (int'(wr_addr_i) < NUM_REGS)) begin
            st_d.regs[wr_addr_i] = wr_data_i;
        end
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [ADDR_W-1:0]               rd_addr_i,
    input  logic                            wr_valid_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    output logic [DATA_W-1:0]               rd_data_o
);
    logic              addr_match;
    logic [DATA_W-1:0] stored_word;

    always_comb begin
        if (rd_addr_i == '0 || int'(rd_addr_i) >= NUM_REGS) begin
            stored_word = '0;
        end else begin
            stored_word = regs_i[rd_addr_i];
        end
        // wr_valid_i is already false for address zero
        addr_match = wr_valid_i && (wr_addr_i == rd_addr_i);
        rd_data_o  = addr_match ? wr_data_i : stored_word;
    end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int NUM_RD = rf_pkg::RF_NUM_RD;

    logic                            wr_valid;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    rf_wr_gate #(.ADDR_W(ADDR_W)) u_wr_gate (
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_valid_o (wr_valid)
    );

    rf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .regs_o     (regs)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
            .regs_i     (regs),
            .rd_addr_i  (rd_addr[p]),
            .wr_valid_i (wr_valid),
            .wr_addr_i  (wr_addr),
            .wr_data_i  (wr_data),
            .rd_data_o  (rd_data[p])
        );
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b
);
    assert_zero_reg_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));
    assert_zero_reg_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    assert_bypass_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd_addr_a && rd_addr_a != '0) |-> (rd_data_a == wr_data));
    assert_bypass_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd_addr_b && rd_addr_b != '0) |-> (rd_data_b == wr_data));

    assert_write_lands_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 &&
         rd_addr_a == $past(wr_addr) && !wr_en) |-> (rd_data_a == $past(wr_data)));
    assert_write_lands_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 &&
         rd_addr_b == $past(wr_addr) && !wr_en) |-> (rd_data_b == $past(wr_data)));

    assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(rd_addr_a)) |-> $stable(rd_data_a));
    assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(rd_addr_b)) |-> $stable(rd_data_b));
endmodule

bind regfile_bypass rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b)
);

// File: tb/regfile_bypass_bench.sv
`timescale 1ns/1ps
module regfile_bypass_bench;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    always #2 clk = ~clk;

    regfile_bypass u_regfile_bypass (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
    );

    typedef struct {
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    event          chk_ev;
    logic [DW-1:0] model [NR];
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    function automatic logic [DW-1:0] expect_read(logic [AW-1:0] ra, logic we,
                                                  logic [AW-1:0] wa, logic [DW-1:0] wd);
        if (ra == '0) return '0;
        if (we && wa == ra) return wd;
        return model[ra];
    endfunction

    // Monitor: compare outputs against the oldest expected item.
    initial begin
        forever begin
            @(chk_ev);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks += 2;
                if (rd_data_a !== it.exp_a) begin
                    n_fail++;
                    $display("FAIL %s port A actual %h expected %h", it.tag, rd_data_a, it.exp_a);
                end
                if (rd_data_b !== it.exp_b) begin
                    n_fail++;
                    $display("FAIL %s port B actual %h expected %h", it.tag, rd_data_b, it.exp_b);
                end
            end
        end
    end

    // Driver: one cycle of stimulus plus its expected outputs.
    task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
        it.exp_a = expect_read(ra, we, wa, wd);
        it.exp_b = expect_read(rb, we, wa, wd);
        it.tag   = tag;
        sb_q.push_back(it);
        #1;
        ->chk_ev;
        @(posedge clk);
        if (we && wa != '0) model[wa] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NR; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        do_reset();
        // R8: reset state
        cyc(1'b0, 5'd0, '0, 5'd5, 5'd31, "R8 reset state");
        cyc(1'b0, 5'd0, '0, 5'd1, 5'd17, "R8 reset state");
        // R4 R5: both ports bypass the register being written
        cyc(1'b1, 5'd5, 32'hA5A5_0001, 5'd5, 5'd5, "R4 R5 dual bypass");
        // R2: write visible next cycle
        cyc(1'b0, 5'd0, '0, 5'd5, 5'd5, "R2 write lands");
        // R7: write to register zero ignored, never bypassed
        cyc(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R7 zero bypass");
        cyc(1'b0, 5'd0, '0, 5'd0, 5'd5, "R7 zero after write");
        // R6: enable low, matching address
        cyc(1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd5, "R6 no bypass when disabled");
        // R3: contents unchanged by disabled write
        cyc(1'b0, 5'd0, '0, 5'd5, 5'd0, "R3 hold");
        // R9: write to r7 while reading r5 and r31
        cyc(1'b1, 5'd7, 32'h0F0F_7777, 5'd5, 5'd31, "R9 other regs unaffected");
        cyc(1'b0, 5'd0, '0, 5'd7, 5'd5, "R9 other regs unaffected");
        // R5: port B alone bypasses
        cyc(1'b1, 5'd9, 32'h9999_0009, 5'd7, 5'd9, "R5 port B bypass");
        cyc(1'b1, 5'd10, 32'hAAAA_000A, 5'd10, 5'd9, "R4 port A bypass");
        // R1 R2: fill every register, then read back all pairs
        for (int i = 1; i < NR; i++) begin
            cyc(1'b1, AW'(i), (DW'(i) * 32'h0101_0101) ^ 32'h5A00_00C3,
                AW'(i - 1), AW'(i), "R2 fill sweep");
        end
        for (int i = 0; i < NR; i++) begin
            cyc(1'b0, 5'd0, '0, AW'(i), AW'(NR - 1 - i), "R1 combinational read");
        end
        // R8: reset mid-run clears all
        do_reset();
        for (int i = 0; i < NR; i += 4) begin
            cyc(1'b0, 5'd0, '0, AW'(i), AW'(i + 1), "R8 reset clears");
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule